// File: doc/BRIEF.md
# Previous-Result-Anchored Successive-Approximation Controller

This block is the digital search engine of a 10-bit successive-approximation converter. A conventional controller restarts every conversion at mid-scale. This one starts each conversion from the code the previous conversion produced. It then walks up or down from that point by a step that halves every cycle. For slowly moving inputs the search therefore stays close to where the signal already was, and the first step can be small.

Each search cycle the controller presents a trial code to the DAC on `dacCode` and samples the one-bit comparator decision `cmp` at the next rising edge. A 1 means the held input is above the trial code. The working code lives in an intermediate register, which feeds the DAC and keeps its final value as the next start point. A separate output register keeps the two most recent results. A range calculator forms their absolute difference with a two's-complement adder. From that difference it picks the size of the first step: a change of d needs a first step larger than d to be reached. Additions and subtractions saturate at the ends of the code range.

Top module: `sarMoveTop`

## Requirements
- R1: While and right after reset, `result` and `dacCode` are 512 and `done` is 0. Both stored results, the latest and the one before it, start at 512.
- R2: In the first search cycle after `start` is sampled in idle, `dacCode` equals the previous `result`.
- R3: In each search cycle with step s, the next trial code is the current code plus s when `cmp` is 1, and minus s when `cmp` is 0.
- R4: An upward move that would pass 1023 gives 1023, and a downward move that would go below 0 gives 0. The code never wraps.
- R5: The first step of a conversion is the smallest power of two strictly greater than the absolute difference between the two most recent results, capped at 512. A difference of 0 gives a step of 1.
- R6: The step halves every cycle, and the search ends after the cycle that uses step 1. If the first step is S, `done` goes high exactly log2(S)+3 rising edges after the edge that samples `start`, counting that edge as the first.
- R7: `done` is high for exactly one cycle. `result` takes the final trial code in that same cycle and holds it until the next `done`.
- R8: `start` is ignored while a conversion is searching or finishing. It changes neither the trial sequence nor the timing.
- R9: While idle, `dacCode` equals `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a conversion when sampled high in idle |
| cmp | input | 1 | Comparator decision: 1 when the held input is above `dacCode` |
| dacCode | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Most recent finished conversion |
| done | output | 1 | One-cycle pulse marking a new `result` |

## Verification
The assertions assume `cmp` is a settled function of the current `dacCode` at each sampling edge. They also assume the analog input does not change during a conversion, since the direction checks only make sense against a stable reference. The bench models the comparator as `input > dacCode` with the input held from before `start` until `done`. Its fixed-seed random inputs, some near the last result and some anywhere in full scale, plus directed runs at both rails, only change between conversions. `start` pulses that land mid-search and during the finishing cycle probe the ignore rule, and they never coincide with a legal start.

// File: rtl/sarMovePkg.sv
package sarMovePkg;

  typedef enum logic [1:0] {
    SAR_IDLE   = 2'd0,
    SAR_SEARCH = 2'd1,
    SAR_FINISH = 2'd2
  } sarState_e;

  // strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic loadSearch;  // seed working code and first step
    logic doStep;      // apply one signed step and halve it
    logic capture;     // shift results: older <= latest <= working
  } sarStrobe_t;

endpackage

// File: rtl/sarRangeCalc.sv
module sarRangeCalc #(
  parameter int W = 10
) (
  input  logic [W-1:0] latest,
  input  logic [W-1:0] older,
  output logic [W-1:0] firstStep
);
  localparam int LOOP_N = W - 1;

  logic [W:0]   rawDiff;
  logic         nonNeg;
  logic [W-1:0] absDiff;

  // latest - older via adder: latest + ~older + 1, carry out = no borrow
  assign rawDiff = {1'b0, latest} + {1'b0, ~older} + {{W{1'b0}}, 1'b1};
  assign nonNeg  = rawDiff[W];
  assign absDiff = nonNeg ? rawDiff[W-1:0] : (~rawDiff[W-1:0] + {{(W-1){1'b0}}, 1'b1});

  // smallest power of two strictly above absDiff, capped at 2^(W-1)
  always_comb begin
    firstStep = {{(W-1){1'b0}}, 1'b1};
    for (int i = 0; i < LOOP_N; i++) begin
      if (firstStep <= absDiff) firstStep = firstStep << 1;
    end
  end

  always_comb begin
    assert_step_pow2_R5: assert ($countones(firstStep) == 1);
  end

endmodule

// File: rtl/sarStepUnit.sv
module sarStepUnit #(
  parameter int W = 10
) (
  input  logic [W-1:0] code,
  input  logic [W-1:0] step,
  input  logic         goUp,
  output logic [W-1:0] nextCode
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W:0]   upSum;
  logic [W-1:0] upCode;
  logic [W-1:0] downCode;

  assign upSum    = {1'b0, code} + {1'b0, step};
  assign upCode   = upSum[W] ? TOP : upSum[W-1:0];
  assign downCode = (code >= step) ? (code - step) : '0;
  assign nextCode = goUp ? upCode : downCode;

endmodule

// File: rtl/sarMoveDatapath.sv
module sarMoveDatapath
  import sarMovePkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sarStrobe_t   strobe,
  input  logic         cmp,
  output logic [W-1:0] workCode,
  output logic [W-1:0] latestResult,
  output logic         lastStep
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] olderResult;
  logic [W-1:0] stepReg;
  logic [W-1:0] firstStep;
  logic [W-1:0] steppedCode;

  sarRangeCalc #(.W(W)) u_range (
    .latest   (latestResult),
    .older    (olderResult),
    .firstStep(firstStep)
  );

  sarStepUnit #(.W(W)) u_step (
    .code    (workCode),
    .step    (stepReg),
    .goUp    (cmp),
    .nextCode(steppedCode)
  );

  assign lastStep = (stepReg == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      workCode <= MID;
      stepReg  <= '0;
    end else if (strobe.loadSearch) begin
      workCode <= latestResult;
      stepReg  <= firstStep;
    end else if (strobe.doStep) begin
      workCode <= steppedCode;
      stepReg  <= stepReg >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latestResult <= MID;
      olderResult  <= MID;
    end else if (strobe.capture) begin
      latestResult <= workCode;
      olderResult  <= latestResult;
    end
  end

  assert_move_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doStep && cmp) |=> (workCode >= $past(workCode)));

  assert_move_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doStep && !cmp) |=> (workCode <= $past(workCode)));

  assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doStep && cmp && ($past(workCode) != '0)) |=> (workCode != '0));

  assert_step_halves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doStep && !lastStep) |=> ($countones(stepReg) == 1));

  assert_shift_older_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> (olderResult == $past(latestResult)));

endmodule

// File: rtl/sarMoveControl.sv
module sarMoveControl
  import sarMovePkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       lastStep,
  output sarStrobe_t strobe,
  output logic       done
);
  sarState_e state;
  sarState_e stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      SAR_IDLE: begin
        if (start) begin
          strobe.loadSearch = 1'b1;
          stateNext         = SAR_SEARCH;
        end
      end
      SAR_SEARCH: begin
        strobe.doStep = 1'b1;
        if (lastStep) stateNext = SAR_FINISH;
      end
      SAR_FINISH: begin
        strobe.capture = 1'b1;
        stateNext      = SAR_IDLE;
      end
      default: stateNext = SAR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SAR_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.capture;
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == SAR_IDLE));

  assert_busy_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SAR_SEARCH && !lastStep) |=> (state == SAR_SEARCH));

endmodule

// File: rtl/sarMoveTop.sv
module sarMoveTop
  import sarMovePkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp,
  output logic [W-1:0] dacCode,
  output logic [W-1:0] result,
  output logic         done
);
  sarStrobe_t strobe;
  logic       lastStep;

  sarMoveControl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .lastStep(lastStep),
    .strobe  (strobe),
    .done    (done)
  );

  sarMoveDatapath #(.W(W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .cmp         (cmp),
    .workCode    (dacCode),
    .latestResult(result),
    .lastStep    (lastStep)
  );

  assert_done_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == $past(dacCode)));

endmodule

// File: tb/sarMoveTop_tb.sv
`timescale 1ns/1ps
module sarMoveTop_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [9:0] vin;
  logic [9:0] dacCode;
  logic [9:0] result;
  logic       done;
  logic       cmp;

  int nCmp = 0;
  int nBad = 0;
  int cyc = 0;
  bit finished = 0;
  int expPrev = 512;
  int expOlder = 512;

  always #2 clk = ~clk;

  assign cmp = (vin > dacCode);

  sarMoveTop u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp(cmp),
    .dacCode(dacCode), .result(result), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pickStep(input int a, input int b);
    int d = (a > b) ? a - b : b - a;
    int s = 1;
    for (int i = 0; i < 9; i++) if (s <= d) s = s * 2;
    return s;
  endfunction

  task automatic convert(input int v, input bit poke, input string moveTag);
    int trace[12];
    int n = 0;
    int c = expPrev;
    int s = pickStep(expPrev, expOlder);
    vin = v[9:0];
    while (s >= 1) begin
      trace[n] = c;
      if (v > c) c = (c + s > 1023) ? 1023 : c + s;
      else       c = (c < s) ? 0 : c - s;
      n++;
      s = s / 2;
    end
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = poke && (k == 0);
      check((k == 0) ? "R2" : moveTag, "trial code", int'(dacCode), trace[k]);
      check("R5", "done during search", int'(done), 0);
      @(posedge clk);
    end
    @(negedge clk);
    start = poke;
    check("R6", "done in finishing cycle", int'(done), 0);
    check(moveTag, "final trial code", int'(dacCode), c);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R6", "done at expected edge", int'(done), 1);
    check("R7", "result at done", int'(result), c);
    expOlder = expPrev;
    expPrev  = c;
    @(posedge clk);
    @(negedge clk);
    check("R7", "done single cycle", int'(done), 0);
    check("R7", "result held", int'(result), c);
    check("R9", "idle dac equals result", int'(dacCode), c);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start = 1'b0;
    vin   = 10'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset result", int'(result), 512);
    check("R1", "reset dac", int'(dacCode), 512);
    check("R1", "reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "result after release", int'(result), 512);

    convert(600, 1'b0, "R3");            // first step 1 from 512
    for (int i = 0; i < 12; i++) convert(1023, 1'b0, "R4");  // climb into top rail
    for (int i = 0; i < 12; i++) convert(0, 1'b0, "R4");     // fall into bottom rail
    convert(512, 1'b1, "R8");
    convert(3, 1'b1, "R8");

    for (int i = 0; i < 400; i++) begin
      int v;
      if ($urandom_range(1, 0) == 1) begin
        v = expPrev + int'($urandom_range(40, 0)) - 20;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
      end else begin
        v = int'($urandom_range(1023, 0));
      end
      convert(v, ($urandom_range(7, 0) == 0), "R3");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule